// File: doc/BRIEF.md
# Set/Way Data-Cache Invalidation Unit

This block executes a cache-maintenance instruction that invalidates one line of a set-associative data cache. The line is named by its set and way, not by its address. The block receives a 32-bit instruction word, the value of the source register, the current privilege level and a one-cycle issue strobe. When the word matches, the privilege is above user mode and the operand selects the first cache level, the block marks the chosen line invalid and clean. Dirty data in that line is dropped. It is never written back.

The way and set indices come from operand bit fields. The positions of those fields follow from the cache geometry parameters: the number of ways, the number of sets and the line size in bytes. The valid/dirty array is kept inside the block. The cache's allocation logic writes lines into the array through a fill port, and the array is observed through a combinational read port. A user-mode attempt produces a one-cycle illegal-instruction pulse and leaves the array untouched. Every other accepted request produces a one-cycle completion pulse.

Top module: `swinv_unit`

## Requirements
- R1: An instruction word matches only when bits [6:0]=0x0B, [11:7]=0, [14:12]=0, [24:20]=0x02 and [31:25]=0x01. Bits [19:15], the source register index, may take any value.
- R2: With privilege code 2'b00 (user), a matching issued word gives `illegal_o`=1 for exactly the next cycle, no `done_o`, and no change to the array. Codes 2'b01, 2'b10 and 2'b11 are all above user mode and are permitted.
- R3: The way index is operand bits [31:32-w], where w=log2(ways).
- R4: The set index is operand bits [l+s-1:l], where s=log2(sets) and l=log2(line bytes).
- R5: Operand bits [3:1] select the cache level, and 0 means the first level. A permitted request with a nonzero level changes nothing in the array but still pulses `done_o`.
- R6: Operand bits outside the way, set and level fields are ignored.
- R7: A permitted level-0 request clears both the valid bit and the dirty bit of the selected line. The change is visible on the read port in the cycle after the issue strobe, and `done_o` is high in that same cycle only.
- R8: Lines other than the selected one keep their valid and dirty state.
- R9: Reset leaves every line invalid and clean, with `done_o` and `illegal_o` low.
- R10: An issued non-matching word raises neither output and leaves the array unchanged.
- R11: A fill marks its line valid, and dirty as given by `fill_dirty_i`, in the cycle after the strobe. When a fill and an invalidation hit the same line in the same cycle, the invalidation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction issue strobe |
| insn_i | input | 32 | Instruction word |
| rs1_i | input | 32 | Source operand carrying the way, set and level fields |
| priv_i | input | 2 | Privilege code, 2'b00 is user mode |
| fill_i | input | 1 | Line allocation strobe |
| fill_way_i | input | log2(NWAYS) | Way being allocated |
| fill_set_i | input | log2(NSETS) | Set being allocated |
| fill_dirty_i | input | 1 | Dirty state of the allocated line |
| rd_way_i | input | log2(NWAYS) | Read port way |
| rd_set_i | input | log2(NSETS) | Read port set |
| rd_valid_o | output | 1 | Valid bit of the addressed line |
| rd_dirty_o | output | 1 | Dirty bit of the addressed line |
| illegal_o | output | 1 | Illegal-instruction pulse |
| done_o | output | 1 | Completion pulse |

## Verification
Every result passes through exactly one register. The completion pulse, the illegal pulse and the array update therefore all appear in the cycle after the edge that samples the issue or fill strobe. The bench drives inputs on falling edges and samples the pulses at the next falling edge, one rising edge later. One cycle after that it checks that both pulses have dropped again. The read port is combinational, so the whole array is swept through it during the low clock phase after each operation and compared with a model kept in the bench.

// File: rtl/swinv_pkg.sv
package swinv_pkg;

  typedef enum logic [1:0] {
    PRV_USER  = 2'b00,
    PRV_SUPV  = 2'b01,
    PRV_HYPV  = 2'b10,
    PRV_MACH  = 2'b11
  } prv_e;

  localparam logic [6:0] ISW_OPCODE = 7'h0B;
  localparam logic [4:0] ISW_RD     = 5'h00;
  localparam logic [2:0] ISW_FUNC3  = 3'h0;
  localparam logic [4:0] ISW_SUBOP  = 5'h02;
  localparam logic [6:0] ISW_FUNC7  = 7'h01;

  // Full-word match of the set/way invalidate encoding; rs1 index is free.
  function automatic logic isw_match(input logic [31:0] insn);
    return (insn[6:0]   == ISW_OPCODE) &&
           (insn[11:7]  == ISW_RD)     &&
           (insn[14:12] == ISW_FUNC3)  &&
           (insn[24:20] == ISW_SUBOP)  &&
           (insn[31:25] == ISW_FUNC7);
  endfunction

  function automatic logic [2:0] level_of(input logic [31:0] op);
    return op[3:1];
  endfunction

endpackage

// File: rtl/swinv_decode.sv
module swinv_decode
  import swinv_pkg::*;
#(
  parameter int WB = 1,
  parameter int SB = 3,
  parameter int LB = 4
) (
  input  logic          issue_i,
  input  logic [31:0]   insn_i,
  input  logic [31:0]   rs1_i,
  input  logic [1:0]    priv_i,
  output logic          ack_o,
  output logic          trap_o,
  output logic          inv_o,
  output logic [WB-1:0] way_o,
  output logic [SB-1:0] set_o
);

  // Way sits at the top of the operand, set just above the line offset.
  function automatic logic [WB-1:0] way_field(input logic [31:0] op);
    return op[31 -: WB];
  endfunction

  function automatic logic [SB-1:0] set_field(input logic [31:0] op);
    return op[LB +: SB];
  endfunction

  logic hit;
  logic is_user;
  logic lvl_zero;

  assign hit      = issue_i && isw_match(insn_i);
  assign is_user  = (prv_e'(priv_i) == PRV_USER);
  assign lvl_zero = (level_of(rs1_i) == 3'd0);

  assign trap_o = hit && is_user;
  assign ack_o  = hit && !is_user;
  assign inv_o  = ack_o && lvl_zero;
  assign way_o  = way_field(rs1_i);
  assign set_o  = set_field(rs1_i);

  // R2: a trap and an acknowledge are never both raised
  always_comb begin
    a_r2_trap_excl: assert (!(trap_o && ack_o));
  end

endmodule

// File: rtl/swinv_lines.sv
module swinv_lines #(
  parameter int WB = 1,
  parameter int SB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_en,
  input  logic [WB-1:0] inv_way,
  input  logic [SB-1:0] inv_set,
  input  logic          fill_en,
  input  logic [WB-1:0] fill_way,
  input  logic [SB-1:0] fill_set,
  input  logic          fill_dirty,
  input  logic [WB-1:0] rd_way,
  input  logic [SB-1:0] rd_set,
  output logic          rd_valid,
  output logic          rd_dirty
);

  localparam int IW    = WB + SB;
  localparam int LINES = 1 << IW;

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] drt_q;
  logic [IW-1:0]    inv_idx;
  logic [IW-1:0]    fill_idx;
  logic [IW-1:0]    rd_idx;
  logic             same_line;

  assign inv_idx   = {inv_way, inv_set};
  assign fill_idx  = {fill_way, fill_set};
  assign rd_idx    = {rd_way, rd_set};
  assign same_line = inv_en && fill_en && (inv_idx == fill_idx);

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    logic kill;
    logic load;
    assign kill = inv_en  && (inv_idx  == IW'(gi));
    assign load = fill_en && (fill_idx == IW'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[gi] <= 1'b0;
        drt_q[gi] <= 1'b0;
      end else if (kill) begin
        vld_q[gi] <= 1'b0;          // dirty data dropped, no writeback
        drt_q[gi] <= 1'b0;
      end else if (load) begin
        vld_q[gi] <= 1'b1;
        drt_q[gi] <= fill_dirty;
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = drt_q[rd_idx];

  // R7: the invalidated line is invalid and clean afterwards
  a_r7_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> (!vld_q[$past(inv_idx)] && !drt_q[$past(inv_idx)]));

  // R8: with no request, no line moves
  a_r8_array_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_en && !fill_en) |=> (vld_q == $past(vld_q) && drt_q == $past(drt_q)));

  // R11: a fill that is not overridden leaves its line valid
  a_r11_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !same_line) |=> vld_q[$past(fill_idx)]);

  // R9: a dirty line is always valid
  a_r9_dirty_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((drt_q & ~vld_q) == '0));

endmodule

// File: rtl/swinv_unit.sv
module swinv_unit #(
  parameter int NWAYS      = 4,
  parameter int NSETS      = 64,
  parameter int LINE_BYTES = 64,
  localparam int WB = $clog2(NWAYS),
  localparam int SB = $clog2(NSETS),
  localparam int LB = $clog2(LINE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [31:0]   insn_i,
  input  logic [31:0]   rs1_i,
  input  logic [1:0]    priv_i,
  input  logic          fill_i,
  input  logic [WB-1:0] fill_way_i,
  input  logic [SB-1:0] fill_set_i,
  input  logic          fill_dirty_i,
  input  logic [WB-1:0] rd_way_i,
  input  logic [SB-1:0] rd_set_i,
  output logic          rd_valid_o,
  output logic          rd_dirty_o,
  output logic          illegal_o,
  output logic          done_o
);

  logic          req_ack;
  logic          req_trap;
  logic          req_inv;
  logic [WB-1:0] req_way;
  logic [SB-1:0] req_set;
  logic          done_q;
  logic          illegal_q;

  swinv_decode #(.WB(WB), .SB(SB), .LB(LB)) u_dec (
    .issue_i (issue_i),
    .insn_i  (insn_i),
    .rs1_i   (rs1_i),
    .priv_i  (priv_i),
    .ack_o   (req_ack),
    .trap_o  (req_trap),
    .inv_o   (req_inv),
    .way_o   (req_way),
    .set_o   (req_set)
  );

  swinv_lines #(.WB(WB), .SB(SB)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_en     (req_inv),
    .inv_way    (req_way),
    .inv_set    (req_set),
    .fill_en    (fill_i),
    .fill_way   (fill_way_i),
    .fill_set   (fill_set_i),
    .fill_dirty (fill_dirty_i),
    .rd_way     (rd_way_i),
    .rd_set     (rd_set_i),
    .rd_valid   (rd_valid_o),
    .rd_dirty   (rd_dirty_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= req_ack;
      illegal_q <= req_trap;
    end
  end

  assign done_o    = done_q;
  assign illegal_o = illegal_q;

  // R7: every acknowledged request completes one cycle later
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> done_o);

  // R2: a user-mode attempt traps and does not complete
  a_r2_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
    req_trap |=> (illegal_o && !done_o));

  // R10: without an issue strobe no pulse follows
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!done_o && !illegal_o));

endmodule

// File: tb/sim_swinv_unit.sv
`timescale 1ns/1ps
module sim_swinv_unit;

  localparam int NW = 2, NS = 8, LBY = 16;
  localparam int LINES = NW * NS;
  localparam logic [31:0] RES_MASK = 32'h7FFF_FF81; // not way[31], set[6:4], level[3:1]

  logic        clk = 0, rst_n = 0;
  logic        issue_i = 0;
  logic [31:0] insn_i = 0, rs1_i = 0;
  logic [1:0]  priv_i = 2'b11;
  logic        fill_i = 0, fill_dirty_i = 0;
  logic [0:0]  fill_way_i = 0, rd_way_i = 0;
  logic [2:0]  fill_set_i = 0, rd_set_i = 0;
  logic        rd_valid_o, rd_dirty_o, illegal_o, done_o;

  int nchk = 0, nfail = 0;
  bit mv [LINES];
  bit md [LINES];

  always #5 clk = ~clk;

  swinv_unit #(.NWAYS(NW), .NSETS(NS), .LINE_BYTES(LBY)) u0 (.*);

  task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input int rsidx);
    return {7'h01, 5'h02, 5'(rsidx), 3'h0, 5'h00, 7'h0B};
  endfunction

  function automatic logic [31:0] mk_rs1(input int way, input int set, input int lvl, input logic [31:0] junk);
    return (32'(way) << 31) | (32'(set) << 4) | (32'(lvl) << 1) | (junk & RES_MASK);
  endfunction

  task automatic check_array(input string req);
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin
        rd_way_i = 1'(w); rd_set_i = 3'(s); #1;
        chk_eq(req, $sformatf("valid w%0d s%0d", w, s), rd_valid_o, mv[w*NS+s]);
        chk_eq(req, $sformatf("dirty w%0d s%0d", w, s), rd_dirty_o, md[w*NS+s]);
      end
  endtask

  task automatic fill_line(input int w, input int s, input bit d);
    @(negedge clk);
    fill_i = 1; fill_way_i = 1'(w); fill_set_i = 3'(s); fill_dirty_i = d;
    @(negedge clk);
    fill_i = 0;
    mv[w*NS+s] = 1; md[w*NS+s] = d;
  endtask

  task automatic do_issue(input logic [31:0] insn, input logic [31:0] op, input logic [1:0] p,
                          input bit exp_done, input bit exp_ill, input string req);
    @(negedge clk);
    issue_i = 1; insn_i = insn; rs1_i = op; priv_i = p;
    @(negedge clk);
    issue_i = 0;
    chk_eq(req, "done pulse", done_o, exp_done);
    chk_eq(req, "illegal pulse", illegal_o, exp_ill);
    @(negedge clk);
    chk_eq(req, "done one cycle", done_o, 0);
    chk_eq(req, "illegal one cycle", illegal_o, 0);
  endtask

  initial begin
    #(1_000_000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    chk_eq("R9", "done after reset", done_o, 0);
    chk_eq("R9", "illegal after reset", illegal_o, 0);
    check_array("R9");

    // R11: allocate every line with a checkerboard dirty pattern
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) fill_line(w, s, bit'((w ^ s) & 1));
    check_array("R11");

    // R2: user mode traps, array unchanged
    do_issue(mk_insn(5), mk_rs1(1, 3, 0, 0), 2'b00, 0, 1, "R2");
    check_array("R2");

    // R5: nonzero level acknowledged, no change
    for (int lv = 1; lv < 8; lv++) begin
      do_issue(mk_insn(lv), mk_rs1(lv & 1, lv, lv, 0), 2'b11, 1, 0, "R5");
      check_array("R5");
    end

    // R10/R1: single-bit corruptions outside the rs1 index field never match
    for (int b = 0; b < 32; b++) begin
      if (b >= 15 && b <= 19) continue;
      do_issue(mk_insn(1) ^ (32'h1 << b), mk_rs1(0, 0, 0, 0), 2'b11, 0, 0, "R10");
    end
    check_array("R10");

    // R1/R3/R4/R6/R7/R8: invalidate every line, varying rs1 index, privilege and reserved junk
    for (int k = 0; k < LINES; k++) begin
      int w = k % NW;
      int s = k / NW;
      logic [1:0] p = 2'(1 + (k % 3));
      do_issue(mk_insn(k), mk_rs1(w, s, 0, 32'h5A5A_0F01 ^ (32'(k) * 32'h0101_0081)), p, 1, 0, "R7");
      mv[w*NS+s] = 0; md[w*NS+s] = 0;
      check_array("R8");
    end

    // R11: simultaneous fill and invalidation of one line; invalidation wins
    fill_line(1, 5, 1);
    fill_line(0, 2, 1);
    @(negedge clk);
    fill_i = 1; fill_way_i = 1; fill_set_i = 5; fill_dirty_i = 1;
    issue_i = 1; insn_i = mk_insn(9); rs1_i = mk_rs1(1, 5, 0, 0); priv_i = 2'b01;
    @(negedge clk);
    fill_i = 0; issue_i = 0;
    chk_eq("R11", "done on collision", done_o, 1);
    mv[1*NS+5] = 0; md[1*NS+5] = 0;
    check_array("R11");

    // R6: all reserved bits set still target the same line
    do_issue(mk_insn(31), mk_rs1(0, 2, 0, 32'hFFFF_FFFF), 2'b10, 1, 0, "R6");
    mv[2] = 0; md[2] = 0;
    check_array("R6");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule